// File: doc/BRIEF.md
# DAC Level Trim Register Bank

This block holds the digital trim state for a group of DAC level channels and produces the 16-bit code each channel's DAC should drive. A channel keeps one register set per operating range. Each set holds a gain code and an offset code. A shared arithmetic unit applies them to a raw level code and caches the result as that set's trimmed code. Because each range's trimmed code is computed ahead of time, a change of operating mode only selects a different cached code, and nothing has to be computed at that moment.

Two channel kinds exist. Wide channels (force level and the two compare levels) keep six sets: one for voltage forcing, four for the internal current ranges and one for the external current range. Clamp channels keep two sets: one for voltage forcing and one shared by all current ranges. Software writes through a single write port that carries channel, set, register kind and data. The write is queued and applied in arrival order. Only a raw-code write starts a computation. A gain or offset write is stored and takes effect at the next raw-code write to that set. A hold input delays updates of the live DAC codes until it is released.

Top module: `dcal_bank`

## Requirements
- R1: A write of kind 1 (gain) or kind 2 (offset) only stores the value. It starts no computation and leaves every DAC code unchanged. The stored value is used by the next kind 0 (raw code) write to the same channel and set.
- R2: A raw-code write computes trimmed = floor(raw × (gain + 1) / 65536) + offset − 32768, clamped to 0x0000..0xFFFF, and caches it in the written set.
- R3: After reset every gain is 0xFFFF, every offset is 0x8000, every cached and live code is 0x0000, and busy and wr_full are low. A raw-code write to an untouched set therefore yields the raw code itself.
- R4: Mode codes 0..5 select voltage forcing, internal current ranges 1 to 4, and the external range. Codes 6 and 7 behave as 0. A wide channel (index below NUM_WIDE) uses the set whose number equals the mode. A clamp channel uses set 0 in mode 0 and set 1 in modes 1 to 5.
- R5: When the mode input changes, every channel's DAC code becomes the cached code of its newly selected set on the next clock edge.
- R6: When a computation finishes for the set that a channel currently uses, that channel's DAC code takes the new value. A computation for any other set changes only the cache.
- R7: Writes are queued in a FIFO and applied in arrival order. busy stays high while any write is queued or being processed. A write presented while wr_full is high is discarded.
- R8: While load_hold is high the DAC codes do not change. Updates are held as pending, and a later pending value for a channel replaces an earlier one. When load_hold goes low, the pending values appear on the next edge.
- R9: A write is discarded without entering the queue if its kind is 3, its channel is NUM_WIDE+NUM_CLAMP or higher, or its set is not below the channel's set count (6 wide, 2 clamp).
- R10: Channel k's code appears on dac_code[16k+15:16k], with wide channels at the low indices and clamp channels after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W (3) | Target channel |
| wr_set | input | 3 | Target register set |
| wr_kind | input | 2 | 0 raw code, 1 gain, 2 offset, 3 reserved |
| wr_data | input | 16 | Write data |
| mode | input | 3 | Operating mode code |
| load_hold | input | 1 | Hold live DAC codes while high |
| busy | output | 1 | Writes queued or computation running |
| wr_full | output | 1 | Write queue full; writes now are discarded |
| dac_code | output | 16·NCH (80) | Live DAC codes, channel 0 in the low bits |

## Verification
A wrong gain or offset inside a set stays hidden until a raw-code write to that set completes. A wrong cached code stays hidden until the mode selects that set. For this reason the bench sweeps every mode after each batch of writes and compares every channel against codes it computes itself. A routing fault in the set mapping or in the pending logic appears at the ports one edge after a mode change or a hold release. Arithmetic faults appear about five edges after the raw-code write that exposes them. The bench samples at both of those points.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
  localparam int DW         = 16;
  localparam int SET_W      = 3;
  localparam int MODE_W     = 3;
  localparam int WIDE_SETS  = 6;
  localparam int CLAMP_SETS = 2;

  typedef enum logic [1:0] {
    K_RAW  = 2'd0,
    K_GAIN = 2'd1,
    K_OFFS = 2'd2,
    K_RSVD = 2'd3
  } kind_e;

  // Set used by a channel in a given mode; modes above 5 fold to 0.
  function automatic logic [SET_W-1:0] pick_set(input logic is_clamp,
                                                input logic [MODE_W-1:0] md);
    logic [SET_W-1:0] m;
    m = (md > 3'd5) ? '0 : md;
    if (is_clamp) return (m != '0) ? SET_W'(1) : SET_W'(0);
    return m;
  endfunction
endpackage

// File: rtl/dcal_fifo.sv
module dcal_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_pop;

  assign do_pop = pop && (level != '0);
  assign dout   = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push)   wp <= (int'(wp) == DEPTH-1) ? '0 : wp + AW'(1);
      if (do_pop) rp <= (int'(rp) == DEPTH-1) ? '0 : rp + AW'(1);
      case ({push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/dcal_math.sv
module dcal_math #(
  parameter int DW = 16,
  localparam int SW = DW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [DW-1:0] raw,
  input  logic [DW-1:0] gain,
  input  logic [DW-1:0] offs,
  output logic          out_v,
  output logic [DW-1:0] out_code
);
  logic [DW:0]     g1;
  logic [2*DW:0]   prod;
  logic [DW:0]     hi;
  logic [DW-1:0]   prod_unused_lo;
  logic            v1;
  logic [DW:0]     hi_q;
  logic [DW-1:0]   offs_q;
  logic [SW-1:0]   sum;

  always_comb begin
    g1   = {1'b0, gain} + (DW+1)'(1);
    prod = (2*DW+1)'(raw) * (2*DW+1)'(g1);
    {hi, prod_unused_lo} = prod;
    sum  = {2'b00, hi_q} + {3'b000, offs_q} - SW'(1 << (DW-1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1       <= 1'b0;
      hi_q     <= '0;
      offs_q   <= '0;
      out_v    <= 1'b0;
      out_code <= '0;
    end else begin
      v1     <= in_v;
      hi_q   <= hi;
      offs_q <= offs;
      out_v  <= v1;
      if (sum[SW-1])            out_code <= '0;
      else if (|sum[SW-2:DW])   out_code <= '1;
      else                      out_code <= sum[DW-1:0];
    end
  end
endmodule

// File: rtl/dcal_live.sv
module dcal_live #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          upd_v,
  input  logic [DW-1:0] upd_code,
  output logic          pend_o,
  output logic [DW-1:0] dac_o
);
  logic [DW-1:0] pend_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_o     <= '0;
      pend_o    <= 1'b0;
      pend_code <= '0;
    end else if (hold) begin
      if (upd_v) begin
        pend_o    <= 1'b1;
        pend_code <= upd_code;
      end
    end else begin
      if (upd_v)       dac_o <= upd_code;
      else if (pend_o) dac_o <= pend_code;
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dcal_bank.sv
module dcal_bank
  import dcal_pkg::*;
#(
  parameter int NUM_WIDE   = 3,
  parameter int NUM_CLAMP  = 2,
  parameter int FIFO_DEPTH = 4,
  localparam int NCH   = NUM_WIDE + NUM_CLAMP,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CH_W-1:0]     wr_ch,
  input  logic [SET_W-1:0]    wr_set,
  input  logic [1:0]          wr_kind,
  input  logic [DW-1:0]       wr_data,
  input  logic [MODE_W-1:0]   mode,
  input  logic                load_hold,
  output logic                busy,
  output logic                wr_full,
  output logic [NCH*DW-1:0]   dac_code
);
  localparam int NREG  = NCH * WIDE_SETS;
  localparam int EW    = CH_W + SET_W + 2 + DW;
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_APPLY, ST_CALC} st_e;

  // write intake
  logic             wr_ok, push, pop, fifo_empty;
  logic [EW-1:0]    fifo_dout;
  logic [LVL_W-1:0] fifo_lvl;

  always_comb begin
    wr_ok = (int'(wr_ch) < NCH) && (wr_kind != K_RSVD);
    if (int'(wr_ch) >= NUM_WIDE) wr_ok = wr_ok && (int'(wr_set) < CLAMP_SETS);
    else                         wr_ok = wr_ok && (int'(wr_set) < WIDE_SETS);
  end

  assign fifo_empty = (fifo_lvl == '0);
  assign wr_full    = (int'(fifo_lvl) == FIFO_DEPTH);
  assign push       = wr_en && wr_ok && !wr_full;

  dcal_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push),
    .din({wr_ch, wr_set, wr_kind, wr_data}),
    .pop(pop), .dout(fifo_dout), .level(fifo_lvl)
  );

  // sequencer and register storage
  st_e              st;
  logic [CH_W-1:0]  cur_ch;
  logic [SET_W-1:0] cur_set;
  kind_e            cur_kind;
  logic [DW-1:0]    cur_data;
  logic [$clog2(NREG)-1:0] cur_ix;

  logic [DW-1:0] gain_mem [NREG];
  logic [DW-1:0] offs_mem [NREG];
  logic [DW-1:0] x2_mem   [NREG];

  logic          go;
  logic [DW-1:0] raw_rd, gain_rd, offs_rd;
  logic          res_v;
  logic [DW-1:0] res_code;

  assign pop    = (st == ST_IDLE) && !fifo_empty;
  assign cur_ix = $clog2(NREG)'(int'(cur_ch) * WIDE_SETS + int'(cur_set));
  assign busy   = (st != ST_IDLE) || !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur_ch   <= '0;
      cur_set  <= '0;
      cur_kind <= K_RAW;
      cur_data <= '0;
      go       <= 1'b0;
      raw_rd   <= '0;
      gain_rd  <= '0;
      offs_rd  <= '0;
      for (int i = 0; i < NREG; i++) begin
        gain_mem[i] <= '1;
        offs_mem[i] <= DW'(1 << (DW-1));
        x2_mem[i]   <= '0;
      end
    end else begin
      go <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (!fifo_empty) begin
            {cur_ch, cur_set} <= fifo_dout[EW-1 -: CH_W+SET_W];
            cur_kind          <= kind_e'(fifo_dout[DW+1:DW]);
            cur_data          <= fifo_dout[DW-1:0];
            st                <= ST_APPLY;
          end
        end
        ST_APPLY: begin
          case (cur_kind)
            K_GAIN: begin
              gain_mem[cur_ix] <= cur_data;
              st <= ST_IDLE;
            end
            K_OFFS: begin
              offs_mem[cur_ix] <= cur_data;
              st <= ST_IDLE;
            end
            K_RAW: begin
              raw_rd  <= cur_data;
              gain_rd <= gain_mem[cur_ix];
              offs_rd <= offs_mem[cur_ix];
              go      <= 1'b1;
              st      <= ST_CALC;
            end
            default: st <= ST_IDLE;
          endcase
        end
        ST_CALC: begin
          if (res_v) begin
            x2_mem[cur_ix] <= res_code;
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  dcal_math #(.DW(DW)) u_math (
    .clk(clk), .rst(rst), .in_v(go), .raw(raw_rd), .gain(gain_rd),
    .offs(offs_rd), .out_v(res_v), .out_code(res_code)
  );

  // live DAC registers
  logic [MODE_W-1:0] mode_q;
  logic              mode_chg;
  logic [NCH-1:0]    pend_vec;
  logic              pend_any;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else     mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);
  assign pend_any = |pend_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam bit IS_CLAMP = (g >= NUM_WIDE);
    logic [SET_W-1:0] eset;
    logic             hit, upd_v;
    logic [DW-1:0]    upd_code;

    always_comb begin
      eset     = pick_set(IS_CLAMP, mode);
      hit      = res_v && (int'(cur_ch) == g) && (cur_set == eset);
      upd_v    = mode_chg || hit;
      upd_code = hit ? res_code : x2_mem[g*WIDE_SETS + int'(eset)];
    end

    dcal_live #(.DW(DW)) u_live (
      .clk(clk), .rst(rst), .hold(load_hold), .upd_v(upd_v),
      .upd_code(upd_code), .pend_o(pend_vec[g]),
      .dac_o(dac_code[g*DW +: DW])
    );
  end
endmodule

// File: rtl/dcal_chk.sv
module dcal_chk
  import dcal_pkg::*;
#(
  parameter int NCH        = 5,
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              load_hold,
  input logic [NCH*DW-1:0] dac_code,
  input logic              busy,
  input logic              wr_full,
  input logic              mode_chg,
  input logic              res_v,
  input kind_e             cur_kind,
  input logic [LVL_W-1:0]  fifo_lvl,
  input logic              pend_any
);
  AST_ONLY_RAW_COMPUTES: assert property (@(posedge clk) disable iff (rst)
    res_v |-> (cur_kind == K_RAW)); // R1

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    $past(load_hold) |-> $stable(dac_code)); // R8

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_chg) && !$past(res_v) && !$past(pend_any)) |-> $stable(dac_code)); // R5

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(fifo_lvl) <= FIFO_DEPTH); // R7

  AST_FULL_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_full |-> busy); // R7

  AST_RESULT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    res_v |-> busy); // R6
endmodule

bind dcal_bank dcal_chk #(.NCH(NCH), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .load_hold(load_hold), .dac_code(dac_code),
  .busy(busy), .wr_full(wr_full), .mode_chg(mode_chg), .res_v(res_v),
  .cur_kind(cur_kind), .fifo_lvl(fifo_lvl), .pend_any(pend_any)
);

// File: tb/sim_dcal_bank.sv
`timescale 1ns/1ps
module sim_dcal_bank;
  localparam int NW = 3, NCL = 2, NCH = 5, FD = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, wr_en, load_hold, busy, wr_full;
  logic [2:0]  wr_ch, wr_set, mode;
  logic [1:0]  wr_kind;
  logic [15:0] wr_data;
  logic [NCH*16-1:0] dac_code;

  dcal_bank #(.NUM_WIDE(NW), .NUM_CLAMP(NCL), .FIFO_DEPTH(FD)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_set(wr_set),
    .wr_kind(wr_kind), .wr_data(wr_data), .mode(mode), .load_hold(load_hold),
    .busy(busy), .wr_full(wr_full), .dac_code(dac_code)
  );

  int total = 0, bad = 0, drops = 0;
  bit done = 0;
  logic [15:0] gm [NCH][6];
  logic [15:0] om [NCH][6];
  logic [15:0] x2m[NCH][6];
  logic [15:0] snap[NCH];

  function automatic logic [15:0] calc(logic [15:0] x, logic [15:0] g, logic [15:0] o);
    longint p;
    p = (longint'(x) * (longint'(g) + 1)) >>> 16;
    p = p + longint'(o) - 32768;
    if (p < 0) return 16'h0000;
    if (p > 65535) return 16'hFFFF;
    return p[15:0];
  endfunction

  function automatic int setof(int ch, int md);
    int m;
    m = (md > 5) ? 0 : md;
    if (ch >= NW) return (m != 0) ? 1 : 0;
    return m;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(int ch, int st, int kind, logic [15:0] d);
    bit ok;
    ok = (ch < NCH) && (kind != 3) && (st < ((ch >= NW) ? 2 : 6));
    if (ok && wr_full) begin ok = 0; drops++; end
    wr_en = 1'b1; wr_ch = 3'(ch); wr_set = 3'(st); wr_kind = 2'(kind); wr_data = d;
    if (ok) begin
      if (kind == 1) gm[ch][st] = d;
      else if (kind == 2) om[ch][st] = d;
      else x2m[ch][st] = calc(d, gm[ch][st], om[ch][st]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(string req);
    for (int c = 0; c < NCH; c++)
      check(req, dac_code[c*16 +: 16], x2m[c][setof(c, int'(mode))]);
  endtask

  task automatic sweep_modes(string req);
    for (int md = 0; md < 8; md++) begin
      mode = 3'(md);
      @(negedge clk);
      check_all(req);
    end
    mode = 3'd0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; wr_ch = 0; wr_set = 0; wr_kind = 0; wr_data = 0;
    mode = 0; load_hold = 0;
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 6; s++) begin
        gm[c][s] = 16'hFFFF; om[c][s] = 16'h8000; x2m[c][s] = 16'h0000;
      end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R3 reset state
    for (int c = 0; c < NCH; c++) check("R3", dac_code[c*16 +: 16], 16'h0000);
    check("R3", 16'(busy), 16'h0);
    check("R3", 16'(wr_full), 16'h0);
    issue(1, 0, 0, 16'h1234);
    wait_idle();
    check("R3", dac_code[16 +: 16], 16'h1234);

    // R1 gain/offset writes store only
    issue(0, 0, 1, 16'h4000);
    wait_idle();
    check_all("R1");
    issue(0, 0, 2, 16'h8100);
    wait_idle();
    check_all("R1");
    issue(0, 0, 0, 16'h8000);
    wait_idle();
    check("R1", dac_code[0 +: 16], 16'h2100);

    // R2 arithmetic sweep on channel 2, set 0
    begin
      logic [15:0] xs[5] = '{16'h0000, 16'h0001, 16'h4000, 16'h8000, 16'hFFFF};
      logic [15:0] gs[4] = '{16'h0000, 16'h3FFF, 16'h4000, 16'hFFFF};
      logic [15:0] os[5] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 5; j++)
          for (int k = 0; k < 5; k++) begin
            issue(2, 0, 1, gs[i]);
            issue(2, 0, 2, os[j]);
            issue(2, 0, 0, xs[k]);
            wait_idle();
            check("R2", dac_code[32 +: 16], calc(xs[k], gs[i], os[j]));
          end
    end

    // R6 inactive set changes cache only
    issue(0, 3, 0, 16'h5A5A);
    wait_idle();
    check_all("R6");

    // fill every valid set with distinct codes
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < ((c >= NW) ? 2 : 6); s++) begin
        issue(c, s, 2, 16'(16'h7000 + c * 16'h0100 + s * 16'h0040));
        issue(c, s, 0, 16'(c * 16'h1111 + s * 16'h0101 + 7));
        wait_idle();
      end
    check_all("R6");
    sweep_modes("R4");
    sweep_modes("R5");
    sweep_modes("R10");

    // R7 queue overflow drops writes
    drops = 0;
    for (int s = 0; s < 6; s++) issue(0, s, 0, 16'(16'hA000 + s));
    issue(3, 0, 0, 16'hB000);
    issue(3, 1, 0, 16'hB001);
    check("R7", 16'(busy), 16'h1);
    check("R7", 16'(drops > 0), 16'h1);
    wait_idle();
    sweep_modes("R7");

    // R9 invalid writes never enter the queue
    issue(5, 0, 0, 16'hDEAD);
    check("R9", 16'(busy), 16'h0);
    issue(3, 2, 0, 16'hBEEF);
    check("R9", 16'(busy), 16'h0);
    issue(0, 0, 3, 16'hCAFE);
    check("R9", 16'(busy), 16'h0);
    issue(1, 6, 1, 16'h0000);
    check("R9", 16'(busy), 16'h0);
    sweep_modes("R9");

    // R8 hold with mode change during hold
    mode = 3'd1;
    wait_idle();
    load_hold = 1;
    for (int c = 0; c < NCH; c++) snap[c] = dac_code[c*16 +: 16];
    issue(0, 1, 0, 16'h1111);
    issue(0, 1, 0, 16'h2222);
    wait_idle();
    for (int c = 0; c < NCH; c++) check("R8", dac_code[c*16 +: 16], snap[c]);
    mode = 3'd2;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R8", dac_code[c*16 +: 16], snap[c]);
    load_hold = 0;
    @(negedge clk);
    check_all("R8");

    // R8 later pending value replaces earlier one
    load_hold = 1;
    for (int c = 0; c < NCH; c++) snap[c] = dac_code[c*16 +: 16];
    issue(0, 2, 0, 16'h3333);
    wait_idle();
    issue(0, 2, 0, 16'h4444);
    wait_idle();
    check("R8", dac_code[0 +: 16], snap[0]);
    load_hold = 0;
    @(negedge clk);
    check("R8", dac_code[0 +: 16], calc(16'h4444, gm[0][2], om[0][2]));
    check_all("R8");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule